// File: doc/BRIEF.md
# Region-Aware Word Address Pointer

This block keeps the byte pointer of a serial memory that holds a 16K x 8 main array plus a few special areas: a 64-byte protected sector, a 16-byte read-only identifier, a lock flag and two configuration registers. When the second word-address byte of a write, or of a dummy write, is acknowledged, the protocol engine pulses a load strobe. It also presents both address bytes and a flag that tells whether the device-type code named the special family. After every data byte moved on the bus, the engine pulses an advance strobe along with the transfer direction.

The block decodes the region from the stored pointer. It steps the pointer with the wrap rule that belongs to that region and to the direction, and it keeps the value between transfers, so a read with no address phase continues where the last one stopped. Both outputs are registered: the region code and the offset inside that region. Each one changes on the clock edge that samples the strobe.

Top module: `word_ptr_unit`

## Requirements
- R1: A synchronous reset sets the pointer to 0 in the main family: region code 0 and offset 0 on the edge after reset is sampled.
- R2: A load takes the pointer from {high byte bits 5:0, low byte}, so bits 7:6 of the high byte have no effect. In the main family the next outputs are region 0 with that 14-bit value as offset.
- R3: A write-direction advance in the main array adds one to bits 5:0 only, going from 63 back to 0, while bits 13:6 stay unchanged.
- R4: A read-direction advance in the main array adds one to the whole 14-bit pointer and goes from 0x3FFF to 0x0000.
- R5: While neither load nor advance is asserted, region and offset hold their values. A later advance continues from the held value.
- R6: In the special family, pointer bits 10:9 pick the region unless R7 applies. A value of 00 gives code 1 (sector, offset = bits 5:0), 01 gives code 2 (identifier, offset = bits 3:0) and 10 gives code 3 (lock flag, offset 0).
- R7: In the special family, pointer 0x06CA gives code 4 (address configuration) and 0x3F35 gives code 5 (configuration write enable). Any other pointer with bits 10:9 = 11 gives code 6 (unmapped). All three report offset 0.
- R8: An advance inside the sector wraps offset 63 to 0, and an advance inside the identifier wraps 15 to 0. Both rules apply in either direction, and the region stays the same.
- R9: An advance in regions 3 to 6 leaves both region and offset unchanged.
- R10: When load and advance are asserted in the same cycle, the load wins, and the loaded value is not stepped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load pointer from the two address bytes |
| fam_spc_i | input | 1 | 1 = special-region device type, 0 = main array |
| wa_hi_i | input | 8 | First word-address byte |
| wa_lo_i | input | 8 | Second word-address byte |
| rd_i | input | 1 | Transfer direction for an advance, 1 = read |
| adv_i | input | 1 | One data byte has been transferred |
| region_o | output | 3 | Region code (see R6, R7) |
| offset_o | output | 14 | Offset inside the region |

## Verification
A load and an advance can be requested in the same cycle, for example when a new address phase starts right after a data byte. The bench raises both strobes in one cycle, with an address whose successor differs from the address itself. It then judges that the outputs show the loaded value and not that value plus one. The boundaries of every wrap rule are reached by loading the address just below each boundary and stepping across it. The behavioural model is compared with the outputs after every clock.

// File: rtl/wap_pkg.sv
package wap_pkg;
  typedef enum logic [2:0] {
    RG_MAIN  = 3'd0,
    RG_SECT  = 3'd1,
    RG_UID   = 3'd2,
    RG_LOCK  = 3'd3,
    RG_CADDR = 3'd4,
    RG_CWREN = 3'd5,
    RG_NONE  = 3'd6
  } region_e;
endpackage

// File: rtl/wap_decode.sv
module wap_decode
  import wap_pkg::*;
#(
  parameter int AW     = 14,
  parameter int SEL_LO = 9,
  parameter int SECT_W = 6,
  parameter int UID_W  = 4,
  parameter logic [AW-1:0] CADDR = 14'h06CA,
  parameter logic [AW-1:0] CWREN = 14'h3F35
) (
  input  logic          fam,
  input  logic [AW-1:0] ptr,
  output region_e       region,
  output logic [AW-1:0] offset
);
  logic [1:0] sel;
  assign sel = ptr[SEL_LO+1:SEL_LO];

  always_comb begin
    region = RG_MAIN;
    offset = '0;
    if (!fam) begin
      region = RG_MAIN;
      offset = ptr;
    end else if (ptr == CADDR) begin
      region = RG_CADDR;
    end else if (ptr == CWREN) begin
      region = RG_CWREN;
    end else begin
      case (sel)
        2'b00: begin
          region = RG_SECT;
          offset = AW'(ptr[SECT_W-1:0]);
        end
        2'b01: begin
          region = RG_UID;
          offset = AW'(ptr[UID_W-1:0]);
        end
        2'b10:   region = RG_LOCK;
        default: region = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/wap_step.sv
module wap_step
  import wap_pkg::*;
#(
  parameter int AW     = 14,
  parameter int PAGE_W = 6,
  parameter int SECT_W = 6,
  parameter int UID_W  = 4
) (
  input  logic [AW-1:0] ptr,
  input  region_e       region,
  input  logic          rd,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] full_inc, page_inc, sect_inc, uid_inc;

  assign full_inc = ptr + AW'(1);
  assign page_inc = {ptr[AW-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
  assign sect_inc = {ptr[AW-1:SECT_W], ptr[SECT_W-1:0] + SECT_W'(1)};
  assign uid_inc  = {ptr[AW-1:UID_W],  ptr[UID_W-1:0]  + UID_W'(1)};

  always_comb begin
    case (region)
      RG_MAIN: nxt = rd ? full_inc : page_inc;
      RG_SECT: nxt = sect_inc;
      RG_UID:  nxt = uid_inc;
      default: nxt = ptr;
    endcase
  end
endmodule

// File: rtl/word_ptr_unit.sv
module word_ptr_unit
  import wap_pkg::*;
#(
  parameter int AW     = 14,
  parameter int WB     = 8,
  parameter int PAGE_W = 6,
  parameter int SECT_W = 6,
  parameter int UID_W  = 4,
  parameter int SEL_LO = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          fam_spc_i,
  input  logic [WB-1:0] wa_hi_i,
  input  logic [WB-1:0] wa_lo_i,
  input  logic          rd_i,
  input  logic          adv_i,
  output logic [2:0]    region_o,
  output logic [AW-1:0] offset_o
);
  localparam int HI_USED = AW - WB;

  logic [AW-1:0] ptr_q, ptr_d, stepped, loaded;
  logic          fam_q, fam_d;
  region_e       region_q, region_d;
  logic [AW-1:0] offset_d;
  logic          unused_hi;

  assign unused_hi = ^wa_hi_i[WB-1:HI_USED];
  assign loaded    = {wa_hi_i[HI_USED-1:0], wa_lo_i};

  wap_step #(.AW(AW), .PAGE_W(PAGE_W), .SECT_W(SECT_W), .UID_W(UID_W)) u_step (
    .ptr(ptr_q), .region(region_q), .rd(rd_i), .nxt(stepped)
  );

  always_comb begin
    ptr_d = ptr_q;
    fam_d = fam_q;
    if (load_i) begin
      ptr_d = loaded;
      fam_d = fam_spc_i;
    end else if (adv_i) begin
      ptr_d = stepped;
    end
  end

  wap_decode #(.AW(AW), .SEL_LO(SEL_LO), .SECT_W(SECT_W), .UID_W(UID_W)) u_dec (
    .fam(fam_d), .ptr(ptr_d), .region(region_d), .offset(offset_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      fam_q    <= 1'b0;
      region_q <= RG_MAIN;
      offset_o <= '0;
    end else begin
      ptr_q    <= ptr_d;
      fam_q    <= fam_d;
      region_q <= region_d;
      offset_o <= offset_d;
    end
  end

  assign region_o = region_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (load_i && !fam_spc_i) |=> (region_o == RG_MAIN &&
      offset_o == {$past(wa_hi_i[HI_USED-1:0]), $past(wa_lo_i)}));

  assert_page_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_i && !rd_i && region_o == RG_MAIN) |=>
      (offset_o[AW-1:PAGE_W] == $past(offset_o[AW-1:PAGE_W]) &&
       offset_o[PAGE_W-1:0] == $past(offset_o[PAGE_W-1:0]) + PAGE_W'(1)));

  assert_read_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_i && rd_i && region_o == RG_MAIN) |=>
      (offset_o == $past(offset_o) + AW'(1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_i) |=> ($stable(offset_o) && $stable(region_o)));

  assert_wrap_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_i && (region_o == RG_SECT || region_o == RG_UID)) |=>
      $stable(region_o));

  assert_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_i && region_o >= 3'd3) |=>
      ($stable(offset_o) && $stable(region_o)));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (load_i && adv_i && !fam_spc_i) |=>
      (offset_o == {$past(wa_hi_i[HI_USED-1:0]), $past(wa_lo_i)}));
endmodule

// File: tb/word_ptr_unit_tb.sv
`timescale 1ns/1ps
module word_ptr_unit_tb;
  logic clk = 1'b0;
  logic rst, load_i, fam_spc_i, rd_i, adv_i;
  logic [7:0] wa_hi_i, wa_lo_i;
  logic [2:0] region_o;
  logic [13:0] offset_o;
  int checks = 0, errors = 0;
  int m_ptr = 0;
  bit m_fam = 0;

  always #4 clk = ~clk;

  word_ptr_unit u_dut (
    .clk(clk), .rst(rst), .load_i(load_i), .fam_spc_i(fam_spc_i),
    .wa_hi_i(wa_hi_i), .wa_lo_i(wa_lo_i), .rd_i(rd_i), .adv_i(adv_i),
    .region_o(region_o), .offset_o(offset_o)
  );

  function automatic void ref_out(input int p, input bit f, output int rg, output int of);
    int sel;
    sel = (p / 512) % 4;
    of = 0;
    if (!f) begin rg = 0; of = p; end
    else if (p == 'h06CA) rg = 4;
    else if (p == 'h3F35) rg = 5;
    else if (sel == 0) begin rg = 1; of = p % 64; end
    else if (sel == 1) begin rg = 2; of = p % 16; end
    else if (sel == 2) rg = 3;
    else rg = 6;
  endfunction

  task automatic cyc(input string tag, input bit r, input bit ld, input bit f,
                     input int hi, input int lo, input bit rd, input bit adv);
    int rg, of;
    rst = r; load_i = ld; fam_spc_i = f; wa_hi_i = hi[7:0]; wa_lo_i = lo[7:0];
    rd_i = rd; adv_i = adv;
    @(posedge clk);
    if (r) begin m_ptr = 0; m_fam = 0; end
    else if (ld) begin m_ptr = (hi % 64) * 256 + (lo % 256); m_fam = f; end
    else if (adv) begin
      ref_out(m_ptr, m_fam, rg, of);
      case (rg)
        0: m_ptr = rd ? (m_ptr + 1) % 16384 : (m_ptr / 64) * 64 + (m_ptr % 64 + 1) % 64;
        1: m_ptr = (m_ptr / 64) * 64 + (m_ptr % 64 + 1) % 64;
        2: m_ptr = (m_ptr / 16) * 16 + (m_ptr % 16 + 1) % 16;
        default: ;
      endcase
    end
    @(negedge clk);
    ref_out(m_ptr, m_fam, rg, of);
    checks++;
    if (int'(region_o) != rg || int'(offset_o) != of) begin
      errors++;
      $display("FAIL %s: actual region=%0d offset=%h expected region=%0d offset=%h",
               tag, region_o, offset_o, rg, of);
    end
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual hang, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; load_i = 0; fam_spc_i = 0; wa_hi_i = 0; wa_lo_i = 0; rd_i = 0; adv_i = 0;
    @(negedge clk);
    cyc("R1 reset", 1, 0, 0, 0, 0, 0, 0);
    cyc("R1 reset hold", 1, 1, 1, 'hFF, 'hFF, 0, 1);
    // R2: top bits of the high byte ignored
    cyc("R2 load", 0, 1, 0, 'hC5, 'h3E, 0, 0);
    for (int i = 0; i < 3; i++) idle("R5 hold");
    // R3: page wrap on write
    for (int i = 0; i < 3; i++) cyc("R3 write step", 0, 0, 0, 0, 0, 0, 1);
    // R4: full-array wrap on read
    cyc("R2 load", 0, 1, 0, 'h3F, 'hFE, 1, 0);
    for (int i = 0; i < 3; i++) cyc("R4 read step", 0, 0, 0, 0, 0, 1, 1);
    cyc("R2 load", 0, 1, 0, 'h00, 'hBF, 0, 0);
    cyc("R4 read across page", 0, 0, 0, 0, 0, 1, 1);
    // R6/R8: sector
    cyc("R6 sector decode", 0, 1, 1, 'h01, 'h3E, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R8 sector wrap", 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 2; i++) cyc("R8 sector read wrap", 0, 0, 0, 0, 0, 1, 1);
    // R6/R8: identifier
    cyc("R6 uid decode", 0, 1, 1, 'h02, 'h0E, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R8 uid wrap", 0, 0, 0, 0, 0, 1, 1);
    // R6/R9: lock flag
    cyc("R6 lock decode", 0, 1, 1, 'h04, 'h55, 0, 0);
    for (int i = 0; i < 2; i++) cyc("R9 lock no step", 0, 0, 0, 0, 0, 1, 1);
    // R7/R9: configuration registers and unmapped
    cyc("R7 caddr decode", 0, 1, 1, 'hC6, 'hCA, 0, 0);
    for (int i = 0; i < 2; i++) cyc("R9 caddr no step", 0, 0, 0, 0, 0, 1, 1);
    cyc("R7 cwren decode", 0, 1, 1, 'h3F, 'h35, 0, 0);
    cyc("R9 cwren no step", 0, 0, 0, 0, 0, 0, 1);
    cyc("R7 unmapped decode", 0, 1, 1, 'h06, 'h00, 0, 0);
    cyc("R9 unmapped no step", 0, 0, 0, 0, 0, 1, 1);
    // R10: load and advance together
    cyc("R10 load wins", 0, 1, 0, 'h12, 'h34, 1, 1);
    cyc("R4 continue", 0, 0, 0, 0, 0, 1, 1);
    idle("R5 hold");
    cyc("R5 resume after hold", 0, 0, 0, 0, 0, 1, 1);
    cyc("R10 load wins write", 0, 1, 0, 'h00, 'h3F, 0, 1);
    cyc("R1 reset mid-run", 1, 1, 1, 'h02, 'h05, 1, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule